// File: doc/BRIEF.md
# Programmable Countdown Timer Unit with Snapshot Read

This block provides a programmable 32-bit countdown timer behind a byte-wide register interface. A control register enables the timer, enables its interrupt, selects a count rate of 1 MHz, 500 kHz or 250 kHz, and selects which value register reads return. The rates are all derived from a 1 MHz tick input. The control register space has two more slots, meant for narrower timers. Those slots, and their value slots, are reserved and read as zero.

The timer counts down once per selected tick. When it is at zero on a tick, it reloads from its load value and sets a sticky expiry flag in a shared status register. Software clears that flag by writing one to it. The interrupt output is asserted while the flag is set and the interrupt enable is on. With the enable off, software can poll the flag instead.

The 32-bit value is read one byte at a time. Reading the least significant byte captures the whole value into a snapshot. The other three bytes then come from that snapshot, in any order, so a count that moves between reads cannot tear the value.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the control register (offset 2), the status register (offset 3), the count, the load value and the `irq` output are all zero.
- R2: While the timer is disabled (control bit 0 = 0), the count follows the load value. The load value is written and read little-endian at offsets 8 to 11.
- R3: When enabled at the full rate (control bits 3:2 = 0), the count decreases by one for each `tick_1mhz` pulse and holds in cycles without a pulse.
- R4: Rate code 1 counts on every second tick after enable, and rate codes 2 and 3 count on every fourth tick. The tick divider restarts whenever the timer is disabled.
- R5: A counting tick that finds the count at zero reloads the load value and sets status bit 2. The period is therefore load+1 counting ticks.
- R6: Status bit 2 is sticky. Writing 1 to bit 2 of offset 3 clears it, and writing 0 leaves it set.
- R7: `irq` equals status bit 2 AND control bit 1 (interrupt enable). While the enable is off the flag still sets, so software can poll it.
- R8: A read of offset 4 returns value byte 0 and captures the full 32-bit value. Reads of offsets 5, 6 and 7 return bytes 1, 2 and 3 of that capture in any order, and they do not capture again.
- R9: Control bit 4 = 0 makes value reads use the live count. Control bit 4 = 1 makes them use the load value.
- R10: Offsets 0, 1 and 12 to 15 are reserved. They read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1mhz | input | 1 | One-cycle pulse at 1 MHz, the base count rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt request |

## Verification
A write or a tick pulse that is sampled on a clock edge changes the count, status and control registers at that same edge. `irq` follows those registers with no further delay. Read data is registered, so it is valid one edge after the read strobe is sampled. The bench drives every input on falling edges. A read task puts the expected byte into a queue, and a monitor compares it against `rdata` on the next falling edge, one cycle after the strobe. Direct checks of `irq` are made on the falling edge that follows the last stimulus edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int NUM_RATES = 3;

  typedef enum logic [1:0] {
    REGION_CTRL  = 2'd0,
    REGION_VALUE = 2'd1,
    REGION_LOAD  = 2'd2,
    REGION_RSVD  = 2'd3
  } region_e;

  localparam int CTRL_SLOT = 2;
  localparam int STAT_SLOT = 3;
  localparam int STAT_BIT  = 2;

  typedef struct packed {
    logic       rd_load;
    logic [1:0] rate;
    logic       ie;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int NRATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  output logic [NRATES-1:0] step_v
);
  localparam int DIV_W = (NRATES > 1) ? NRATES - 1 : 1;

  logic [DIV_W-1:0] div_q, div_nxt;

  always_comb begin
    div_nxt = div_q;
    if (!run)      div_nxt = '0;
    else if (tick) div_nxt = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end

  for (genvar k = 0; k < NRATES; k++) begin : g_rate
    if (k == 0) begin : g_full
      assign step_v[k] = run & tick;
    end else begin : g_div
      assign step_v[k] = run & tick & (&div_q[k-1:0]);
      AST_SLOWER_IMPLIES_FASTER: assert property (@(posedge clk) disable iff (!rst_n)
        step_v[k] |-> step_v[k-1]); // R4
    end
  end
endmodule

// File: rtl/tmr_down_counter.sv
`timescale 1ns/1ps
module tmr_down_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    expire  = 1'b0;
    if (!run) begin
      cnt_nxt = load_val;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_nxt = load_val;
        expire  = 1'b1;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> (cnt_q == $past(cnt_q))); // R3
  AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && cnt_q == '0) |=> (cnt_q == $past(load_val))); // R5
  AST_DISABLED_TRACKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(load_val))); // R2
endmodule

// File: rtl/tmr_snapshot.sv
`timescale 1ns/1ps
module tmr_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] src,
  output logic [W-1:0] snap
);
  logic [W-1:0] snap_q, snap_nxt;

  always_comb snap_nxt = cap ? src : snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_nxt;
  end

  assign snap = snap_q;
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int TMR_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam int NBYTES = TMR_W / 8;
  localparam int BSEL_W = $clog2(NBYTES);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  region_e           region;
  logic [BSEL_W-1:0] bsel;
  assign region = region_e'(addr[ADDR_W-1:BSEL_W]);
  assign bsel   = addr[BSEL_W-1:0];

  logic ctrl_wr, stat_wr, snap_cap;
  assign ctrl_wr  = wr_en && region == REGION_CTRL && bsel == BSEL_W'(CTRL_SLOT);
  assign stat_wr  = wr_en && region == REGION_CTRL && bsel == BSEL_W'(STAT_SLOT);
  assign snap_cap = rd_en && region == REGION_VALUE && bsel == '0;

  // control register
  ctrl_t ctrl_q, ctrl_nxt;
  always_comb ctrl_nxt = ctrl_wr ? ctrl_t'(wdata[4:0]) : ctrl_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_nxt;
  end

  // load value, byte-writable
  logic [TMR_W-1:0] load_q, load_nxt;
  for (genvar b = 0; b < NBYTES; b++) begin : g_load
    always_comb
      load_nxt[b*8 +: 8] = (wr_en && region == REGION_LOAD && bsel == BSEL_W'(b))
                           ? wdata : load_q[b*8 +: 8];
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) load_q <= '0;
    else             load_q <= load_nxt;
  end

  // rate selection
  logic [NUM_RATES-1:0] step_v;
  logic [1:0]           rate_idx;
  logic                 step;
  assign rate_idx = (int'(ctrl_q.rate) >= NUM_RATES) ? 2'(NUM_RATES - 1) : ctrl_q.rate;
  assign step     = step_v[rate_idx];

  tmr_prescale #(.NRATES(NUM_RATES)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (ctrl_q.en),
    .tick   (tick_1mhz),
    .step_v (step_v)
  );

  logic [TMR_W-1:0] count;
  logic             expire;
  tmr_down_counter #(.W(TMR_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (ctrl_q.en),
    .step     (step),
    .load_val (load_q),
    .count    (count),
    .expire   (expire)
  );

  // sticky status flag, write 1 to clear, set wins
  logic stat_q, stat_nxt;
  always_comb stat_nxt = expire | (stat_q & ~(stat_wr & wdata[STAT_BIT]));
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stat_q <= 1'b0;
    else             stat_q <= stat_nxt;
  end

  assign irq = stat_q & ctrl_q.ie;

  // snapshot of the selected source
  logic [TMR_W-1:0] src, snap;
  assign src = ctrl_q.rd_load ? load_q : count;

  tmr_snapshot #(.W(TMR_W)) u_snapshot (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap   (snap_cap),
    .src   (src),
    .snap  (snap)
  );

  // read data
  logic [7:0] rdata_q, rdata_nxt;
  always_comb begin
    rdata_nxt = 8'h00;
    unique case (region)
      REGION_CTRL: begin
        if (bsel == BSEL_W'(CTRL_SLOT))      rdata_nxt = {3'b000, ctrl_q};
        else if (bsel == BSEL_W'(STAT_SLOT)) rdata_nxt = 8'(stat_q) << STAT_BIT;
      end
      REGION_VALUE: rdata_nxt = (bsel == '0) ? src[7:0] : snap[bsel*8 +: 8];
      REGION_LOAD:  rdata_nxt = load_q[bsel*8 +: 8];
      default:      rdata_nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= 8'h00;
    else if (rd_en)  rdata_q <= rdata_nxt;
  end
  assign rdata = rdata_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_q.ie |-> !irq); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_q && !(stat_wr && wdata[STAT_BIT])) |=> stat_q); // R6
  AST_SNAP_NO_RELATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && region == REGION_VALUE && bsel != '0) |=> $stable(snap)); // R8
  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> stat_q); // R5
endmodule

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1mhz = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1mhz (tick_1mhz),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq)
  );

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string      t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, actual %h", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1mhz = 1'b1;
      @(negedge clk); tick_1mhz = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic set_load(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(4'(8 + b), v[b*8 +: 8]);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(4'd2, 8'h00, "R1 ctrl");
    rd(4'd3, 8'h00, "R1 status");
    rd(4'd4, 8'h00, "R1 count");
    rd(4'd8, 8'h00, "R1 load");

    // R10 reserved slots
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wr(4'd12, 8'hFF); wr(4'd15, 8'hFF);
    rd(4'd0, 8'h00, "R10 off0");
    rd(4'd1, 8'h00, "R10 off1");
    for (int a = 12; a < 16; a++) rd(4'(a), 8'h00, "R10 value slot");
    rd(4'd2, 8'h00, "R10 ctrl untouched");

    // R2 disabled count follows load
    set_load(32'h1122_3344);
    rd(4'd8, 8'h44, "R2 load b0");
    rd(4'd11, 8'h11, "R2 load b3");
    rd(4'd4, 8'h44, "R2 count b0");
    rd(4'd5, 8'h33, "R2 count b1");
    rd(4'd6, 8'h22, "R2 count b2");
    rd(4'd7, 8'h11, "R2 count b3");

    // R3 full rate countdown
    set_load(32'd5);
    wr(4'd2, 8'h01);
    ticks(2);
    rd(4'd4, 8'h03, "R3 after two ticks");
    repeat (10) @(negedge clk);
    rd(4'd4, 8'h03, "R3 holds without tick");

    // R9 read source select
    wr(4'd2, 8'h11);
    rd(4'd4, 8'h05, "R9 load selected");
    wr(4'd2, 8'h01);
    rd(4'd4, 8'h03, "R9 live selected");

    // R5 reload and status, R7 masked polling
    ticks(3);
    rd(4'd4, 8'h00, "R5 reached zero");
    rd(4'd3, 8'h00, "R5 no flag at zero");
    ticks(1);
    rd(4'd4, 8'h05, "R5 reloaded");
    rd(4'd3, 8'h04, "R5 flag set");
    chk_irq(1'b0, "R7 masked");
    wr(4'd2, 8'h03);
    chk_irq(1'b1, "R7 enabled");

    // R6 write-one-to-clear
    wr(4'd3, 8'h00);
    rd(4'd3, 8'h04, "R6 write zero keeps");
    chk_irq(1'b1, "R6 irq kept");
    wr(4'd3, 8'h04);
    rd(4'd3, 8'h00, "R6 cleared");
    chk_irq(1'b0, "R6 irq cleared");

    // R4 half rate
    wr(4'd2, 8'h00);
    set_load(32'd10);
    wr(4'd2, 8'h05);
    ticks(1);
    rd(4'd4, 8'h0A, "R4 half first tick");
    ticks(3);
    rd(4'd4, 8'h08, "R4 half four ticks");

    // R4 quarter rate
    wr(4'd2, 8'h00);
    wr(4'd2, 8'h09);
    ticks(3);
    rd(4'd4, 8'h0A, "R4 quarter three ticks");
    ticks(1);
    rd(4'd4, 8'h09, "R4 quarter fourth tick");
    ticks(4);
    rd(4'd4, 8'h08, "R4 quarter eight ticks");
    wr(4'd2, 8'h00);
    wr(4'd2, 8'h0D);
    ticks(4);
    rd(4'd4, 8'h09, "R4 code three quarter");

    // R8 snapshot
    wr(4'd2, 8'h00);
    set_load(32'h0000_0100);
    wr(4'd2, 8'h01);
    rd(4'd4, 8'h00, "R8 capture b0");
    ticks(1);
    rd(4'd5, 8'h01, "R8 snap b1");
    rd(4'd7, 8'h00, "R8 snap b3");
    rd(4'd6, 8'h00, "R8 snap b2");
    rd(4'd5, 8'h01, "R8 snap b1 again");
    rd(4'd4, 8'hFF, "R8 recapture b0");
    rd(4'd5, 8'h00, "R8 new snap b1");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule